// File: doc/BRIEF.md
# Indexed Register Front End for a USB Device Controller

This block is the register access front end of a USB device controller. A local processor reaches it over a parallel bus that runs either 8 or 16 bits wide, as chosen by a static mode pin. The block holds two kinds of register. The first is the device address register, which has an enable bit and a 7-bit USB address. The second is a set of per-endpoint registers, which are reached through an endpoint index register. The block drives the active device address and the enable bit to the packet decoder, which compares incoming token addresses against them.

Firmware writes a new device address, but that value stays pending. It only becomes active after the host acknowledges the empty status packet. The packet logic signals that event with a one-cycle `status_ack` pulse. On the narrow bus, each 16-bit register takes two accesses, low byte first. A byte pointer keeps track of which half comes next. That pointer starts again at the low byte whenever a different offset is addressed.

The bus uses single-cycle strobes and never stalls, so it has no ready signal and no back-pressure. Read data is registered. It appears one cycle after the read strobe, together with a one-cycle `rd_valid`. Offset map: 0x0 device address, 0x1 endpoint index, 0x2 buffer length, 0x4 maximum packet size, 0x6 data port, 0x8 endpoint type, 0x9 control function, 0xA short packet. The last six are banked per endpoint.

Top module: `usb_reg_front`

## Requirements
- R1: The device address register is at offset 0x0. Bit 7 is the device enable and bits 6:0 are the address. A read returns the last value written, and a 16-bit write stores only the low byte.
- R2: A write to offset 0x0 does not change `dev_en` or `dev_addr`. In the cycle after a `status_ack` pulse, those outputs take the pending register value: `dev_en` from bit 7 and `dev_addr` from bits 6:0.
- R3: `rst_n` low, or a one-cycle `bus_reset` or `soft_reset` pulse, clears both the pending and the active address to zero. The reset takes priority over a write or an acknowledge in the same cycle.
- R4: With `bus_wide`=0, a 16-bit register (offsets 0x2, 0x4, 0x6) is moved one byte per access, low byte first, then alternating. The byte uses `wdata[7:0]` and `rdata[7:0]`, and `rdata[15:8]` reads zero.
- R5: On the narrow bus, any access to an offset other than the previous one restarts the byte pointer. The next access to a 16-bit register then moves its low byte. An access in 16-bit mode also leaves the pointer at the low byte.
- R6: With `bus_wide`=1, a 16-bit register is moved whole in one access. Single-byte registers take `wdata[7:0]`, and a read of one returns zero in `rdata[15:8]`.
- R7: The endpoint index register is at offset 0x1. A write of a value of `NUM_EP` or more is ignored and the index keeps its old value. The index reads back zero-extended.
- R8: Accesses to offsets 0x2 to 0xA reach only the endpoint selected by the index. Every endpoint keeps its own storage, and all of it resets to zero.
- R9: Read data and `rd_valid` appear in the cycle after `rd_en`, and `rd_valid` lasts one cycle. When `wr_en` and `rd_en` are high together, only the write is performed and `rd_valid` stays low.
- R10: Offsets outside the map read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| bus_reset | input | 1 | USB bus reset pulse, clears the address |
| soft_reset | input | 1 | Soft reset pulse, clears the address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_off | input | 4 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle |
| status_ack | input | 1 | Status stage acknowledged, commits the pending address |
| dev_en | output | 1 | Active device enable |
| dev_addr | output | 7 | Active device address |

## Verification
The assertions check the following on every cycle:
- The active address moves only on an acknowledge or a reset, and after an acknowledge it equals the pending value.
- A reset pulse clears both address registers.
- The endpoint index never leaves its legal range, and an out-of-range write leaves it unchanged.
- The narrow-bus byte pointer alternates on repeated accesses and restarts on a change of offset.
- A read is answered one cycle later unless a write collides with it.

Only the bench scenarios can show that bytes land in the right lane of the right endpoint. They also show that interleaved accesses to two registers rebuild the expected 16-bit values, and that unmapped and out-of-range writes leave the stored state as it was.

// File: rtl/rif_pkg.sv
package rif_pkg;

  localparam int OFF_W  = 4;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    FLD_NONE,
    FLD_DEVADDR,
    FLD_EPIDX,
    FLD_BUFLEN,
    FLD_MAXPKT,
    FLD_DPORT,
    FLD_EPTYPE,
    FLD_CTRL,
    FLD_SHORT
  } field_e;

  typedef struct packed {
    logic [DATA_W-1:0] buflen;
    logic [DATA_W-1:0] maxpkt;
    logic [DATA_W-1:0] dport;
    logic [BYTE_W-1:0] eptype;
    logic [BYTE_W-1:0] ctrl;
    logic [BYTE_W-1:0] shortp;
  } ep_regs_t;

  function automatic field_e decode_field(input logic [OFF_W-1:0] off);
    case (off)
      4'h0:    return FLD_DEVADDR;
      4'h1:    return FLD_EPIDX;
      4'h2:    return FLD_BUFLEN;
      4'h4:    return FLD_MAXPKT;
      4'h6:    return FLD_DPORT;
      4'h8:    return FLD_EPTYPE;
      4'h9:    return FLD_CTRL;
      4'hA:    return FLD_SHORT;
      default: return FLD_NONE;
    endcase
  endfunction

  function automatic logic field_is_wide(input field_e f);
    return (f == FLD_BUFLEN) || (f == FLD_MAXPKT) || (f == FLD_DPORT);
  endfunction

  function automatic logic field_is_banked(input field_e f);
    return (f == FLD_BUFLEN) || (f == FLD_MAXPKT) || (f == FLD_DPORT) ||
           (f == FLD_EPTYPE) || (f == FLD_CTRL)   || (f == FLD_SHORT);
  endfunction

  function automatic logic [DATA_W-1:0] merge16(input logic [DATA_W-1:0] old,
                                                input logic [1:0]        be,
                                                input logic [DATA_W-1:0] d);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction

endpackage

// File: rtl/rif_byte_seq.sv
module rif_byte_seq #(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access,
  input  logic [OFF_W-1:0] off,
  input  logic             multi,
  input  logic             wide,
  output logic             hi_sel
);

  logic [OFF_W-1:0] last_off;
  logic             last_vld;
  logic             ptr;

  // Upper byte only when a narrow access repeats the same 16-bit register.
  assign hi_sel = !wide && multi && last_vld && (last_off == off) && ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_off <= '0;
      last_vld <= 1'b0;
      ptr      <= 1'b0;
    end else if (access) begin
      last_off <= off;
      last_vld <= 1'b1;
      ptr      <= (!wide && multi) ? !hi_sel : 1'b0;
    end
  end

  AST_NARROW_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !wide && multi) |=>
      (!(access && !wide && off == $past(off)) || (hi_sel != $past(hi_sel)))); // R4

  AST_SWITCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> ((off == $past(off)) || !hi_sel)); // R5

  AST_WIDE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (access && wide) |=> !hi_sel); // R5

endmodule

// File: rtl/rif_addr_reg.sv
module rif_addr_reg #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [AW:0]   wbyte,
  input  logic          ack,
  output logic [AW:0]   pending,
  output logic          act_en,
  output logic [AW-1:0] act_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= '0;
      act_en   <= 1'b0;
      act_addr <= '0;
    end else if (clr) begin
      pending  <= '0;
      act_en   <= 1'b0;
      act_addr <= '0;
    end else begin
      if (wr)  pending <= wbyte;
      if (ack) begin
        act_en   <= pending[AW];
        act_addr <= pending[AW-1:0];
      end
    end
  end

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !clr) |=> $stable({act_en, act_addr})); // R2

  AST_ACK_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !clr) |=> ({act_en, act_addr} == $past(pending))); // R2

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pending == '0 && !act_en && act_addr == '0)); // R3

endmodule

// File: rtl/rif_ep_bank.sv
module rif_ep_bank
  import rif_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] idx_wdata,
  input  field_e            fld,
  input  logic              wr,
  input  logic [1:0]        be,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rd_field
);

  ep_regs_t bank [NUM_EP];
  ep_regs_t cur;
  logic     idx_ok;
  logic     idx_legal_wr;

  assign idx_legal_wr = int'(idx_wdata) < NUM_EP;
  assign idx_ok       = int'(idx) < NUM_EP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      idx <= '0;
    else if (idx_wr && idx_legal_wr) idx <= idx_wdata[IDX_W-1:0];
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank[g] <= '0;
      end else if (wr && idx == IDX_W'(g)) begin
        case (fld)
          FLD_BUFLEN: bank[g].buflen <= merge16(bank[g].buflen, be, wdata);
          FLD_MAXPKT: bank[g].maxpkt <= merge16(bank[g].maxpkt, be, wdata);
          FLD_DPORT:  bank[g].dport  <= merge16(bank[g].dport, be, wdata);
          FLD_EPTYPE: if (be[0]) bank[g].eptype <= wdata[7:0];
          FLD_CTRL:   if (be[0]) bank[g].ctrl   <= wdata[7:0];
          FLD_SHORT:  if (be[0]) bank[g].shortp <= wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cur = idx_ok ? bank[idx] : '0;
    case (fld)
      FLD_BUFLEN: rd_field = cur.buflen;
      FLD_MAXPKT: rd_field = cur.maxpkt;
      FLD_DPORT:  rd_field = cur.dport;
      FLD_EPTYPE: rd_field = {8'h00, cur.eptype};
      FLD_CTRL:   rd_field = {8'h00, cur.ctrl};
      FLD_SHORT:  rd_field = {8'h00, cur.shortp};
      default:    rd_field = '0;
    endcase
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < NUM_EP); // R7

  AST_IDX_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !idx_legal_wr) |=> $stable(idx)); // R7

endmodule

// File: rtl/usb_reg_front.sv
module usb_reg_front
  import rif_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wide,
  input  logic              bus_reset,
  input  logic              soft_reset,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  input  logic              status_ack,
  output logic              dev_en,
  output logic [6:0]        dev_addr
);

  field_e            fld;
  logic              multi;
  logic              access;
  logic              rd_fire;
  logic              hi_sel;
  logic [1:0]        be;
  logic [DATA_W-1:0] wlane;
  logic [BYTE_W-1:0] pending;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] full_rd;
  logic [DATA_W-1:0] rd_next;

  assign fld     = decode_field(reg_off);
  assign multi   = field_is_wide(fld);
  assign access  = wr_en | rd_en;
  assign rd_fire = rd_en & ~wr_en;

  rif_byte_seq #(.OFF_W(OFF_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .access (access),
    .off    (reg_off),
    .multi  (multi),
    .wide   (bus_wide),
    .hi_sel (hi_sel)
  );

  always_comb begin
    if (bus_wide) begin
      be    = multi ? 2'b11 : 2'b01;
      wlane = wdata;
    end else begin
      be    = hi_sel ? 2'b10 : 2'b01;
      wlane = {wdata[7:0], wdata[7:0]};
    end
  end

  rif_addr_reg #(.AW(7)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (bus_reset | soft_reset),
    .wr       (wr_en && fld == FLD_DEVADDR),
    .wbyte    (wlane[7:0]),
    .ack      (status_ack),
    .pending  (pending),
    .act_en   (dev_en),
    .act_addr (dev_addr)
  );

  rif_ep_bank #(.NUM_EP(NUM_EP)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (wr_en && fld == FLD_EPIDX),
    .idx_wdata (wlane[7:0]),
    .fld       (fld),
    .wr        (wr_en && field_is_banked(fld)),
    .be        (be),
    .wdata     (wlane),
    .idx       (idx),
    .rd_field  (bank_rd)
  );

  always_comb begin
    case (fld)
      FLD_DEVADDR: full_rd = {8'h00, pending};
      FLD_EPIDX:   full_rd = DATA_W'(idx);
      FLD_NONE:    full_rd = '0;
      default:     full_rd = bank_rd;
    endcase
    if (bus_wide) rd_next = full_rd;
    else          rd_next = {8'h00, hi_sel ? full_rd[15:8] : full_rd[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rdata <= rd_next;
    end
  end

  AST_RD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid); // R9

  AST_WR_BLOCKS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_valid); // R9

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !bus_wide) |=> (rdata[15:8] == 8'h00)); // R4

  AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !multi) |=> (rdata[15:8] == 8'h00)); // R6

endmodule

// File: tb/tb_usb_reg_front.sv
`timescale 1ns/1ps
module tb_usb_reg_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wide = 1'b1;
  logic        bus_reset = 1'b0;
  logic        soft_reset = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  reg_off = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid;
  logic        status_ack = 1'b0;
  logic        dev_en;
  logic [6:0]  dev_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  usb_reg_front #(.NUM_EP(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide), .bus_reset(bus_reset),
    .soft_reset(soft_reset), .wr_en(wr_en), .rd_en(rd_en), .reg_off(reg_off),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .status_ack(status_ack),
    .dev_en(dev_en), .dev_addr(dev_addr)
  );

  // {is_read, wide, offset, value}: value is write data or expected read data
  localparam int NV = 30;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'h1, 16'h0003},  // R7 select endpoint 3
    {1'b0, 1'b0, 4'h2, 16'h0034},  // R4 low byte
    {1'b0, 1'b0, 4'h2, 16'h0012},  // R4 high byte
    {1'b1, 1'b0, 4'h2, 16'h0034},  // R4
    {1'b1, 1'b0, 4'h2, 16'h0012},  // R4
    {1'b0, 1'b1, 4'h4, 16'hBEEF},  // R6 whole word
    {1'b1, 1'b0, 4'h4, 16'h00EF},  // R5 after wide access
    {1'b1, 1'b0, 4'h2, 16'h0034},  // R5 switch
    {1'b1, 1'b0, 4'h4, 16'h00EF},  // R5 switch
    {1'b1, 1'b1, 4'h4, 16'hBEEF},  // R6
    {1'b0, 1'b1, 4'h8, 16'hAB5C},  // R6 single-byte low lane
    {1'b1, 1'b1, 4'h8, 16'h005C},  // R6
    {1'b0, 1'b1, 4'h1, 16'h0005},  // R7
    {1'b1, 1'b1, 4'h2, 16'h0000},  // R8 other endpoint untouched
    {1'b0, 1'b1, 4'h1, 16'h0009},  // R7 out of range
    {1'b1, 1'b1, 4'h1, 16'h0005},  // R7 ignored
    {1'b0, 1'b1, 4'h1, 16'h0003},  // R8
    {1'b1, 1'b1, 4'h2, 16'h1234},  // R8
    {1'b0, 1'b1, 4'hC, 16'hFFFF},  // R10
    {1'b1, 1'b1, 4'hC, 16'h0000},  // R10
    {1'b0, 1'b1, 4'h0, 16'h00A5},  // R1
    {1'b1, 1'b1, 4'h0, 16'h00A5},  // R1
    {1'b0, 1'b0, 4'h2, 16'h0077},  // R5
    {1'b1, 1'b0, 4'h4, 16'h00EF},  // R5
    {1'b0, 1'b0, 4'h2, 16'h0066},  // R5 restart at low
    {1'b1, 1'b1, 4'h2, 16'h1266},  // R5
    {1'b0, 1'b1, 4'h9, 16'h00C3},  // R8
    {1'b0, 1'b1, 4'hA, 16'h0011},  // R8
    {1'b1, 1'b1, 4'h9, 16'h00C3},  // R8
    {1'b1, 1'b0, 4'hA, 16'h0011}   // R4 single byte on narrow bus
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input bit wide, input logic [3:0] off, input logic [15:0] d);
    @(negedge clk);
    bus_wide = wide; reg_off = off; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input bit wide, input logic [3:0] off, input logic [15:0] exp,
                          input string req);
    @(negedge clk);
    bus_wide = wide; reg_off = off; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid === 1'b1, req, {15'b0, rd_valid}, 16'h0001);
    check(rdata === exp, req, rdata, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) status_ack = 1'b1;
    else if (which == 1) bus_reset = 1'b1;
    else soft_reset = 1'b1;
    @(negedge clk);
    status_ack = 1'b0; bus_reset = 1'b0; soft_reset = 1'b0;
  endtask

  task automatic check_dev(input logic [7:0] exp, input string req);
    check({dev_en, dev_addr} === exp, req, {8'h00, dev_en, dev_addr}, {8'h00, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    check_dev(8'h00, "R3");
    check(rd_valid === 1'b0, "R3", {15'b0, rd_valid}, 16'h0000);
    check(rdata === 16'h0000, "R3", rdata, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21])
        bus_read(VEC[i][20], VEC[i][19:16], VEC[i][15:0], $sformatf("R4-R10 vector %0d", i));
      else
        bus_write(VEC[i][20], VEC[i][19:16], VEC[i][15:0]);
    end

    // R2 pending address not yet active
    check_dev(8'h00, "R2");
    pulse(0);
    check_dev(8'hA5, "R2");
    bus_write(1'b1, 4'h0, 16'h0011);
    check_dev(8'hA5, "R2");
    bus_read(1'b1, 4'h0, 16'h0011, "R1");
    pulse(0);
    check_dev(8'h11, "R2");

    // R3 bus reset and soft reset
    pulse(1);
    check_dev(8'h00, "R3");
    bus_read(1'b1, 4'h0, 16'h0000, "R3");
    bus_write(1'b1, 4'h0, 16'h00FF);
    pulse(0);
    check_dev(8'hFF, "R1");
    pulse(2);
    check_dev(8'h00, "R3");
    bus_read(1'b1, 4'h0, 16'h0000, "R3");

    // R9 write wins over a simultaneous read
    @(negedge clk);
    bus_wide = 1'b1; reg_off = 4'h9; wdata = 16'h0044; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rd_valid === 1'b0, "R9", {15'b0, rd_valid}, 16'h0000);
    bus_read(1'b1, 4'h9, 16'h0044, "R9");
    @(negedge clk);
    check(rd_valid === 1'b0, "R9", {15'b0, rd_valid}, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule